// File: doc/BRIEF.md
# Memory Powerdown Entry and Exit Sequencer

This controller-side block takes a memory device into its self-refreshing powerdown state and brings it back, issuing every command in an order that keeps all rows refreshed. On an entry request it closes all banks, refreshes every bank once at the current row without moving the row pointer, stays silent for a quiet interval, sends the powerdown command, and after a further delay allows the memory clock and termination to be switched off.

On an exit request it withdraws the clock-off permission, waits for the clock to settle, and asks for a broadcast write to the device's power-management register. When that write has finished it waits out the wake-up delay. It then sends one refresh per bank, and the last of these advances the row pointer. A catch-up burst follows. Its length covers the refreshes the device missed during the wake-up window, and every refresh that falls on the last bank also advances the row pointer.

Commands leave on a valid/ready port. While `cmd_valid` is high and `cmd_ready` is low, the opcode and bank hold steady. A command counts as issued in the cycle where both are high. The serial write request follows the same rule. The serial engine reports the end of the write with a one-cycle `ser_done`.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset the block is active and idle: `cmd_valid`, `ser_valid`, `clk_gate_ok`, `busy`, `done` and `err` are all low.
- R2: An entry request accepted while active and idle puts its first command up in the next cycle: precharge-all (opcode 1, bank 0). It is followed at once by NUM_BANKS bank refreshes (opcode 2) for banks 0 upward in order. None of these uses opcode 3.
- R3: After the last entry refresh is issued, `cmd_valid` stays low for exactly T_QUIET cycles and the powerdown command (opcode 4, bank 0) follows.
- R4: `clk_gate_ok` first rises T_CLKOFF+1 cycles after the powerdown command is issued, together with a one-cycle `done`. It stays high until the cycle after an exit request. While it is high, neither `cmd_valid` nor `ser_valid` is high.
- R5: `ser_valid` first rises T_CLKSTABLE+1 cycles after the exit request, carrying address 0x03 and data 0x01.
- R6: After `ser_done`, `cmd_valid` stays low for exactly T_WAKE cycles, and the first command is then a bank refresh (opcode 2) of bank 0.
- R7: The exit burst holds NUM_BANKS refreshes of banks 0 to NUM_BANKS-1 in order. Only the last one uses opcode 3.
- R8: Right after the exit burst, a catch-up burst of ceil(NUM_BANKS*ROWS_PER_BANK*T_WAKE/T_REFWIN) refreshes is issued. Entry i (counting from 0) addresses bank i mod NUM_BANKS and uses opcode 3 when that bank is NUM_BANKS-1, otherwise opcode 2. `done` pulses in the cycle after the last one is issued, and the block is active and idle again.
- R9: A command or serial request that is not accepted stays valid with unchanged content until it is accepted.
- R10: An entry request made when the block is not active and idle, or an exit request made when it is not asleep, gives a one-cycle `err` in the next cycle and does not change the command stream.
- R11: `busy` is high from the cycle after an accepted request until the sequence ends: it falls in the cycle where `clk_gate_ok` rises after entry, and in the cycle of `done` after exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_req | input | 1 | Request to start powerdown entry |
| exit_req | input | 1 | Request to start powerdown exit |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted when high together with valid |
| cmd_op | output | 3 | Opcode: 1 precharge-all, 2 bank refresh, 3 refresh with row increment, 4 powerdown |
| cmd_bank | output | $clog2(NUM_BANKS) | Bank addressed by a refresh |
| ser_valid | output | 1 | Broadcast serial register write requested |
| ser_ready | input | 1 | Serial engine accepts the request |
| ser_addr | output | 8 | Serial register address (0x03) |
| ser_data | output | 8 | Serial write data (0x01) |
| ser_done | input | 1 | One-cycle pulse when the serial write has finished |
| clk_gate_ok | output | 1 | Memory clock and termination may be removed |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench uses eight banks of 4096 rows and short waits: quiet 5, clock-off 4, clock-stable 6 and wake-up 20 cycles. It sets a refresh window of 40000 cycles, so the catch-up count comes to 17 after rounding up from about 16.4. With that count the catch-up burst wraps the bank index twice and carries two row-increment refreshes, so both the rounding and the every-eighth rule are visible. The full entry and exit cycle runs twice, once with `cmd_ready` always high and once with pseudo-random back-pressure. Rejected requests are placed in the idle, busy and asleep states.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_PRECH_ALL = 3'd1,
    OP_REF_BANK  = 3'd2,
    OP_REF_INC   = 3'd3,
    OP_POWERDOWN = 3'd4
  } pd_op_e;

  typedef enum logic [1:0] {
    BM_ENTRY,
    BM_EXIT,
    BM_CATCH
  } burst_mode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_EREF,
    S_QUIET,
    S_PDN,
    S_GATEWAIT,
    S_SLEEP,
    S_STABLE,
    S_SWR,
    S_SWAIT,
    S_WAKE,
    S_XREF,
    S_CATCH
  } pd_state_e;

  localparam logic [7:0] SER_PM_ADDR = 8'h03;
  localparam logic [7:0] SER_PM_WAKE = 8'h01;

endpackage

// File: rtl/pdseq_timer.sv
module pdseq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/pdseq_burst.sv
module pdseq_burst
  import pdseq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CATCH_N   = 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_MAX  = (NUM_BANKS > CATCH_N) ? NUM_BANKS : CATCH_N,
  localparam int IW       = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  burst_mode_e       mode,
  output pd_op_e            op,
  output logic [BANK_W-1:0] bank,
  output logic              last
);

  localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(NUM_BANKS - 1);

  logic [IW-1:0] idx;
  logic          row_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      bank <= '0;
    end else if (clr) begin
      idx  <= '0;
      bank <= '0;
    end else if (adv) begin
      idx  <= idx + 1'b1;
      bank <= (bank == TOP_BANK) ? '0 : bank + 1'b1;
    end
  end

  assign row_end = (bank == TOP_BANK);

  // Entry refreshes never move the row pointer; the other bursts advance it
  // on every refresh that lands on the highest bank.
  always_comb begin
    op = OP_REF_BANK;
    if (mode != BM_ENTRY && row_end) op = OP_REF_INC;
  end

  assign last = (mode == BM_CATCH) ? (idx == IW'(CATCH_N - 1))
                                   : (idx == IW'(NUM_BANKS - 1));

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pdseq_pkg::*;
#(
  parameter int NUM_BANKS     = 8,
  parameter int ROWS_PER_BANK = 4096,
  parameter int T_QUIET       = 8,
  parameter int T_CLKOFF      = 16,
  parameter int T_CLKSTABLE   = 32,
  parameter int T_WAKE        = 64,
  parameter int T_REFWIN      = 6400000,
  localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_req,
  input  logic              exit_req,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output pd_op_e            cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              ser_valid,
  input  logic              ser_ready,
  output logic [7:0]        ser_addr,
  output logic [7:0]        ser_data,
  input  logic              ser_done,
  output logic              clk_gate_ok,
  output logic              busy,
  output logic              done,
  output logic              err
);

  // Refreshes owed for the wake-up window, rounded up at elaboration.
  localparam longint REF_WORK = longint'(NUM_BANKS) * longint'(ROWS_PER_BANK) * longint'(T_WAKE);
  localparam int     CATCH_N  = int'((REF_WORK + longint'(T_REFWIN) - 1) / longint'(T_REFWIN));
  localparam bit     HAS_CATCH = (CATCH_N > 0);
  localparam int     TM_A  = (T_QUIET > T_CLKOFF) ? T_QUIET : T_CLKOFF;
  localparam int     TM_B  = (T_CLKSTABLE > T_WAKE) ? T_CLKSTABLE : T_WAKE;
  localparam int     T_MAX = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int     TW    = $clog2(T_MAX + 1);

  pd_state_e         state, state_n;
  logic              cmd_hs, ser_hs, in_burst;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              burst_clr, burst_last;
  burst_mode_e       burst_mode;
  pd_op_e            burst_op;
  logic [BANK_W-1:0] burst_bank;
  logic              reject;

  assign in_burst = (state == S_EREF) || (state == S_XREF) || (state == S_CATCH);
  assign cmd_valid = in_burst || (state == S_PRE) || (state == S_PDN);
  assign cmd_hs    = cmd_valid && cmd_ready;
  assign ser_valid = (state == S_SWR);
  assign ser_hs    = ser_valid && ser_ready;
  assign ser_addr  = SER_PM_ADDR;
  assign ser_data  = SER_PM_WAKE;

  always_comb begin
    state_n = state;
    unique case (state)
      S_IDLE:     if (enter_req)            state_n = S_PRE;
      S_PRE:      if (cmd_hs)               state_n = S_EREF;
      S_EREF:     if (cmd_hs && burst_last) state_n = S_QUIET;
      S_QUIET:    if (tmr_zero)             state_n = S_PDN;
      S_PDN:      if (cmd_hs)               state_n = S_GATEWAIT;
      S_GATEWAIT: if (tmr_zero)             state_n = S_SLEEP;
      S_SLEEP:    if (exit_req)             state_n = S_STABLE;
      S_STABLE:   if (tmr_zero)             state_n = S_SWR;
      S_SWR:      if (ser_hs)               state_n = S_SWAIT;
      S_SWAIT:    if (ser_done)             state_n = S_WAKE;
      S_WAKE:     if (tmr_zero)             state_n = S_XREF;
      S_XREF:     if (cmd_hs && burst_last) state_n = HAS_CATCH ? S_CATCH : S_IDLE;
      S_CATCH:    if (cmd_hs && burst_last) state_n = S_IDLE;
      default:                              state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= state_n;
      done  <= (state == S_GATEWAIT && tmr_zero) ||
               (cmd_hs && burst_last &&
                ((state == S_XREF && !HAS_CATCH) || state == S_CATCH));
      err   <= reject;
    end
  end

  assign reject = (enter_req && state != S_IDLE) || (exit_req && state != S_SLEEP);

  // Every wait state is loaded on entry and left when the count reaches zero.
  always_comb begin
    tmr_load = (state_n != state);
    unique case (state_n)
      S_QUIET:    tmr_val = TW'(T_QUIET - 1);
      S_GATEWAIT: tmr_val = TW'(T_CLKOFF - 1);
      S_STABLE:   tmr_val = TW'(T_CLKSTABLE - 1);
      S_WAKE:     tmr_val = TW'(T_WAKE - 1);
      default: begin
        tmr_val  = '0;
        tmr_load = 1'b0;
      end
    endcase
  end

  pdseq_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign burst_clr  = !in_burst || (cmd_hs && burst_last);
  assign burst_mode = (state == S_EREF) ? BM_ENTRY :
                      (state == S_XREF) ? BM_EXIT  : BM_CATCH;

  pdseq_burst #(.NUM_BANKS(NUM_BANKS), .CATCH_N(CATCH_N)) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (burst_clr),
    .adv   (cmd_hs),
    .mode  (burst_mode),
    .op    (burst_op),
    .bank  (burst_bank),
    .last  (burst_last)
  );

  always_comb begin
    cmd_op   = OP_NONE;
    cmd_bank = '0;
    if (state == S_PRE)      cmd_op = OP_PRECH_ALL;
    else if (state == S_PDN) cmd_op = OP_POWERDOWN;
    else if (in_burst) begin
      cmd_op   = burst_op;
      cmd_bank = burst_bank;
    end
  end

  assign busy        = !(state == S_IDLE || state == S_SLEEP);
  assign clk_gate_ok = (state == S_SLEEP);

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_bank));

  // R9
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && !ser_ready |=> ser_valid);

  // R4
  gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_ok |-> !cmd_valid && !ser_valid);

  // R4
  gate_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_ok) |-> done);

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(enter_req || exit_req));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/pwrdn_seq_bench.sv
module pwrdn_seq_bench;
  import pdseq_pkg::*;

  localparam int NB  = 8;
  localparam int RW  = 4096;
  localparam int TQ  = 5;
  localparam int TC  = 4;
  localparam int TS  = 6;
  localparam int TWK = 20;
  localparam int TRW = 40000;
  localparam int M   = (NB * RW * TWK + TRW - 1) / TRW;
  localparam int BIG = 1 << 30;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       enter_req = 1'b0, exit_req = 1'b0;
  logic       cmd_ready = 1'b0, ser_ready = 1'b0, ser_done = 1'b0;
  logic       cmd_valid, ser_valid, clk_gate_ok, busy, done, err;
  pd_op_e     cmd_op;
  logic [2:0] cmd_bank;
  logic [7:0] ser_addr, ser_data;

  pwrdn_seq #(.NUM_BANKS(NB), .ROWS_PER_BANK(RW), .T_QUIET(TQ), .T_CLKOFF(TC),
              .T_CLKSTABLE(TS), .T_WAKE(TWK), .T_REFWIN(TRW)) u_pwrdn_seq (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .ser_valid(ser_valid), .ser_ready(ser_ready), .ser_addr(ser_addr), .ser_data(ser_data),
    .ser_done(ser_done), .clk_gate_ok(clk_gate_ok), .busy(busy), .done(done), .err(err)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  int q_op[$], q_bank[$], q_gap[$], q_ref[$];
  string q_tag[$];
  int ev_cyc = 0, exit_cyc = BIG, last_hs = 0;
  int g_on = BIG, g_off = BIG, b_from = BIG, b_to = BIG;
  int done_at = -1, err_at = -1, ser_done_at = -1, ser_cnt = 0;
  bit mon_on = 0, bp = 0, in_exit = 0, finished = 0;
  bit pv = 0, pr = 0, spv = 0, spr = 0;
  int pop = 0, pb = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push(input int op, input int bank, input int gap, input int rf, input string tag);
    q_op.push_back(op); q_bank.push_back(bank); q_gap.push_back(gap);
    q_ref.push_back(rf); q_tag.push_back(tag);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Reference model: expected command queue plus per-cycle flag windows.
  always @(negedge clk) begin
    bit r, hs, newc;
    int o, b, rf;
    if (mon_on && !finished) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = bp ? (lfsr[0] | lfsr[5]) : 1'b1;
      cmd_ready = r;
      hs = cmd_valid && r;
      o = int'(cmd_op);
      b = int'(cmd_bank);
      if (pv && !pr) // R9
        chk(cmd_valid && o == pop && b == pb, "R9", "held command op*100+bank", o * 100 + b, pop * 100 + pb);
      newc = cmd_valid && !(pv && !pr);
      if (newc) begin
        if (q_op.size() == 0) chk(1'b0, "R10", "unexpected command op", o, -1);
        else begin
          chk(o == q_op[0] && b == q_bank[0], q_tag[0], "command op*100+bank", o * 100 + b, q_op[0] * 100 + q_bank[0]);
          rf = q_ref[0] ? ev_cyc : last_hs;
          chk(cyc - rf == q_gap[0], q_tag[0], "cycles before command", cyc - rf, q_gap[0]);
        end
      end
      if (hs) begin
        last_hs = cyc;
        if (q_op.size() > 0) begin
          if (q_op[0] == 4) begin
            g_on = cyc + TC + 1; g_off = BIG; b_to = g_on; done_at = g_on;
          end
          void'(q_op.pop_front()); void'(q_bank.pop_front()); void'(q_gap.pop_front());
          void'(q_ref.pop_front()); void'(q_tag.pop_front());
          if (in_exit && q_op.size() == 0) begin
            b_to = cyc + 1; done_at = cyc + 1; in_exit = 0;
          end
        end
      end
      pv = cmd_valid; pr = r; pop = o; pb = b;

      if (ser_valid) ser_cnt++; else ser_cnt = 0;
      ser_ready = (ser_cnt >= 3);
      if (spv && !spr) chk(ser_valid, "R9", "serial request held", int'(ser_valid), 1);
      if (ser_valid && ser_cnt == 1) begin // R5
        chk(cyc == exit_cyc + TS + 1, "R5", "serial write start cycle", cyc, exit_cyc + TS + 1);
        chk(ser_addr == 8'h03 && ser_data == 8'h01, "R5", "serial addr*256+data",
            int'(ser_addr) * 256 + int'(ser_data), 3 * 256 + 1);
      end
      if (ser_valid && ser_ready) ser_done_at = cyc + 3;
      if (cyc == ser_done_at) begin ser_done = 1'b1; ev_cyc = cyc; end
      else ser_done = 1'b0;
      spv = ser_valid; spr = ser_ready;

      chk(clk_gate_ok == (cyc >= g_on && cyc < g_off), "R4", "clock gate permit", int'(clk_gate_ok), int'(cyc >= g_on && cyc < g_off));
      chk(busy == (cyc >= b_from && cyc < b_to), "R11", "busy", int'(busy), int'(cyc >= b_from && cyc < b_to));
      chk(done == (cyc == done_at), "R8", "done pulse", int'(done), int'(cyc == done_at));
      chk(err == (cyc == err_at), "R10", "error pulse", int'(err), int'(cyc == err_at));
    end
  end

  always @(negedge clk) begin
    if (cyc > 20000 && !finished) begin
      chk(1'b0, "R11", "watchdog expired", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!cmd_valid, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
    chk(!ser_valid, "R1", "ser_valid after reset", int'(ser_valid), 0);
    chk(!clk_gate_ok, "R1", "clk_gate_ok after reset", int'(clk_gate_ok), 0);
    chk(!busy, "R1", "busy after reset", int'(busy), 0);
    chk(!done && !err, "R1", "done|err after reset", int'(done | err), 0);
    mon_on = 1;
    for (int rnd = 0; rnd < 2; rnd++) begin
      bp = (rnd == 1);
      // R10: exit while awake and idle
      @(negedge clk);
      exit_req = 1'b1; err_at = cyc + 1;
      @(negedge clk);
      exit_req = 1'b0;
      repeat (3) @(negedge clk);

      // R2, R3: entry sequence
      push(1, 0, 1, 1, "R2");
      for (int k = 0; k < NB; k++) push(2, k, 1, 0, "R2");
      push(4, 0, TQ + 1, 0, "R3");
      enter_req = 1'b1; ev_cyc = cyc; b_from = cyc + 1; b_to = BIG;
      @(negedge clk);
      enter_req = 1'b0;
      repeat (2) @(negedge clk);
      // R10: both requests while busy
      enter_req = 1'b1; exit_req = 1'b1; err_at = cyc + 1;
      @(negedge clk);
      enter_req = 1'b0; exit_req = 1'b0;
      while (!clk_gate_ok) @(negedge clk);
      repeat (2) @(negedge clk);
      // R10: entry while asleep
      enter_req = 1'b1; err_at = cyc + 1;
      @(negedge clk);
      enter_req = 1'b0;
      repeat (2) @(negedge clk);

      // R6, R7, R8: exit sequence
      push(2, 0, TWK + 1, 1, "R6");
      for (int k = 1; k < NB; k++) push((k == NB - 1) ? 3 : 2, k, 1, 0, "R7");
      for (int i = 0; i < M; i++) push(((i % NB) == NB - 1) ? 3 : 2, i % NB, 1, 0, "R8");
      in_exit = 1;
      exit_req = 1'b1; exit_cyc = cyc; g_off = cyc + 1; b_from = cyc + 1; b_to = BIG;
      @(negedge clk);
      exit_req = 1'b0;
      while (q_op.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
    end
    finish_run();
  end

endmodule